// File: doc/BRIEF.md
# I2C Register-File Target

This block is a target device on a two-wire serial bus. It holds a small internal array of byte-wide registers, similar to a serial EEPROM. The bus master can write one or more bytes starting at any register address. It can read them back through a dummy write followed by a repeated START, or it can read on from wherever the internal pointer was left.

Both bus wires enter through two-flop synchronisers on the system clock. Bus conditions and clock edges are recovered from the synchronised values, so the system clock must run at least eight times faster than SCL. The block never drives SDA high. It produces only a pull-down enable, and the surrounding pad or bench resolves the open-drain line.

The array holds 2^ADDR_BITS bytes. When ADDR_BITS exceeds 8, the register address on the bus takes two bytes, sent high byte first. Otherwise it takes a single byte.

Top module: `i2cRegSlave`

## Requirements
- R1: While reset is asserted, and after it is released, the pull-down enable `sdaOe` is 0, so SDA stays released.
- R2: SDA falling while SCL is high (START) returns the block to control-byte reception from any state. SDA rising while SCL is high (STOP) sends it to idle with SDA released. In idle, bytes clocked without a new START are not acknowledged.
- R3: A control byte whose bits 7:4 are not 4'b1010 is not acknowledged. The rest of that transfer is ignored: no register changes, and SDA is never pulled low until the next START.
- R4: In a write-direction transfer, the block pulls SDA low (acknowledge = 0) during the ninth SCL pulse after the control byte, after each address byte and after each data byte.
- R5: With ADDR_BITS ≤ 8 the register address is one byte. With ADDR_BITS > 8 it is two bytes, high byte first, and only the low ADDR_BITS bits of the pair are kept.
- R6: Each data byte written is stored at the pointer, and each byte written or read advances the pointer by one, wrapping from the last register to register 0.
- R7: A random read is a control byte with bit 0 = 0, then the address bytes, then a repeated START, then a control byte with bit 0 = 1. The block then returns the addressed register, MSB first.
- R8: After a read byte, if the master holds SDA low in the ninth pulse, the next register is sent. If SDA is high there, the block releases SDA and sends nothing more until a START or STOP.
- R9: A control byte with bit 0 = 1 that follows a START directly, with no address phase, reads from the current pointer.
- R10: The block changes its SDA drive only while SCL is low. The only exception is the release at a START or STOP.
- R11: A START arriving in the middle of a data byte discards that partial byte. The register at the pointer keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus (resolved open-drain level) |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Every change on `sdaOe` lands three system clocks after the SCL edge that causes it: two synchroniser stages plus the drive register. Acknowledges and read data therefore appear shortly after SCL falls. The bench model changes its own SDA a quarter of an SCL period (10 clocks) after each SCL edge. It samples SDA 10 clocks into the high phase and again 10 clocks later, well clear of that three-clock window. Direct checks of `sdaOe` are taken only at a quarter period after a falling SCL, when any response from the block must already have landed.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  // Control-to-datapath strobes, one clock wide each.
  typedef struct packed {
    logic shiftIn;   // shift the sampled SDA into the receive byte
    logic addrByte;  // fold the received byte into the pointer
    logic writeMem;  // store the received byte at the pointer, then advance
    logic loadTx;    // fetch the register at the pointer, drive its MSB, advance
    logic shiftTx;   // drive the next transmit bit
    logic ackDrive;  // pull SDA low for an acknowledge
    logic relOe;     // release SDA
  } regStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDRHI,
    ST_ADDRLO,
    ST_WDATA,
    ST_RDATA
  } slvStateT;

  localparam logic [3:0] CTRL_TAG = 4'b1010;

endpackage

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int ADDR_BITS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  regStrobeT str,
  output logic      sclRise,
  output logic      sclFall,
  output logic      startDet,
  output logic      stopDet,
  output logic      sdaSmp,
  output logic      tagMatch,
  output logic      rdDir,
  output logic      sdaOe
);

  localparam int DEPTH = 1 << ADDR_BITS;

  logic [1:0] sclSync, sdaSync;
  logic       sclNow, sclPrev, sdaPrev;
  logic [7:0] rxByte;
  logic [6:0] txRest;
  logic [ADDR_BITS-1:0] ptr, addrLoad;
  logic [7:0] mem [DEPTH];
  logic [7:0] memRd;

  // Two-flop synchronisers plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaSmp   = sdaSync[1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaSmp;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaSmp;

  assign tagMatch = (rxByte[7:4] == CTRL_TAG);
  assign rdDir    = rxByte[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (str.shiftIn) rxByte <= {rxByte[6:0], sdaSmp};
  end

  // Address bytes shift into the pointer; a wide array keeps the low bits of two bytes.
  generate
    if (ADDR_BITS > 8) begin : g_wideAddr
      assign addrLoad = {ptr[ADDR_BITS-9:0], rxByte};
    end else begin : g_narrowAddr
      assign addrLoad = rxByte[ADDR_BITS-1:0];
    end
  endgenerate

  assign memRd = mem[ptr];

  always_ff @(posedge clk) begin
    if (str.writeMem) mem[ptr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      txRest <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (str.addrByte) ptr <= addrLoad;
      else if (str.writeMem || str.loadTx) ptr <= ptr + 1'b1;

      if (str.loadTx) txRest <= memRd[6:0];
      else if (str.shiftTx) txRest <= {txRest[5:0], 1'b0};

      if (str.relOe) sdaOe <= 1'b0;
      else if (str.ackDrive) sdaOe <= 1'b1;
      else if (str.loadTx) sdaOe <= ~memRd[7];
      else if (str.shiftTx) sdaOe <= ~txRest[6];
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet) && !$past(stopDet)) |-> !sclNow); // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (str.writeMem || str.loadTx) |=> (ptr == $past(ptr) + 1'b1)); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R2
  AST_ACK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    str.ackDrive |=> sdaOe); // R4

endmodule

// File: rtl/i2cRegControl.sv
module i2cRegControl
  import i2cRegPkg::*;
#(
  parameter int ADDR_BYTES = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaSmp,
  input  logic      tagMatch,
  input  logic      rdDir,
  output regStrobeT str
);

  localparam slvStateT FIRST_ADDR = (ADDR_BYTES == 2) ? ST_ADDRHI : ST_ADDRLO;

  slvStateT   state, stateNxt;
  logic [3:0] bitCnt, bitNxt;
  logic       ackPhase, ackNxt;
  logic       slaveAck, slvNxt;
  logic       mstAckLow, contNxt;

  always_comb begin
    str      = '0;
    stateNxt = state;
    bitNxt   = bitCnt;
    ackNxt   = ackPhase;
    slvNxt   = slaveAck;
    contNxt  = mstAckLow;
    if (startDet || stopDet) begin
      stateNxt  = startDet ? ST_CTRL : ST_IDLE;
      bitNxt    = '0;
      ackNxt    = 1'b0;
      slvNxt    = 1'b0;
      str.relOe = 1'b1;
    end else if (state == ST_RDATA) begin
      if (!ackPhase) begin
        if (sclRise && bitCnt < 4'd8) begin
          bitNxt = bitCnt + 4'd1;
        end else if (sclFall && bitCnt == 4'd8) begin
          str.relOe = 1'b1;
          ackNxt    = 1'b1;
        end else if (sclFall && bitCnt != 4'd0) begin
          str.shiftTx = 1'b1;
        end
      end else if (sclRise && !slaveAck) begin
        contNxt = ~sdaSmp;
      end else if (sclFall) begin
        ackNxt = 1'b0;
        slvNxt = 1'b0;
        bitNxt = '0;
        if (slaveAck || mstAckLow) begin
          str.loadTx = 1'b1;
        end else begin
          str.relOe = 1'b1;
          stateNxt  = ST_IDLE;
        end
      end
    end else if (state != ST_IDLE) begin
      if (!ackPhase) begin
        if (sclRise && bitCnt < 4'd8) begin
          str.shiftIn = 1'b1;
          bitNxt      = bitCnt + 4'd1;
        end else if (sclFall && bitCnt == 4'd8) begin
          if (state == ST_CTRL && !tagMatch) begin
            stateNxt = ST_IDLE;
          end else begin
            str.ackDrive = 1'b1;
            ackNxt       = 1'b1;
            slvNxt       = 1'b1;
            case (state)
              ST_CTRL:   stateNxt = rdDir ? ST_RDATA : FIRST_ADDR;
              ST_ADDRHI: begin str.addrByte = 1'b1; stateNxt = ST_ADDRLO; end
              ST_ADDRLO: begin str.addrByte = 1'b1; stateNxt = ST_WDATA; end
              default:   str.writeMem = 1'b1;
            endcase
          end
        end
      end else if (sclFall) begin
        ackNxt    = 1'b0;
        slvNxt    = 1'b0;
        bitNxt    = '0;
        str.relOe = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      slaveAck  <= 1'b0;
      mstAckLow <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= bitNxt;
      ackPhase  <= ackNxt;
      slaveAck  <= slvNxt;
      mstAckLow <= contNxt;
    end
  end

  AST_START_TO_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_CTRL)); // R2
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter int ADDR_BITS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  localparam int ADDR_BYTES = (ADDR_BITS > 8) ? 2 : 1;

  regStrobeT str;
  logic sclRise, sclFall, startDet, stopDet, sdaSmp, tagMatch, rdDir;

  i2cRegControl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaSmp   (sdaSmp),
    .tagMatch (tagMatch),
    .rdDir    (rdDir),
    .str      (str)
  );

  i2cRegDatapath #(.ADDR_BITS(ADDR_BITS)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .str      (str),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaSmp   (sdaSmp),
    .tagMatch (tagMatch),
    .rdDir    (rdDir),
    .sdaOe    (sdaOe)
  );

endmodule

// File: tb/i2cRegSlave_tb.sv
module i2cRegSlave_tb;

  localparam int QTR = 10;
  localparam int NVEC = 6;
  // {register address[3:0], data[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{12'h13C, 12'h200, 12'h7FF, 12'h481, 12'hA5A, 12'hCE7};

  logic clk = 1'b0;
  always #2.5ns clk = ~clk;

  logic rstN, scl, mDrvLow, sel;
  logic oeA, oeB, sdaA, sdaB, line;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  assign sdaA = ~(mDrvLow | oeA);
  assign sdaB = ~(mDrvLow | oeB);
  assign line = sel ? sdaB : sdaA;

  i2cRegSlave u_dut (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaA), .sdaOe(oeA));
  i2cRegSlave #(.ADDR_BITS(9)) u_dut2 (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaB), .sdaOe(oeB));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic startCond();
    mDrvLow = 1'b0; waitQ();
    scl = 1'b1;     waitQ();
    mDrvLow = 1'b1; waitQ();
    scl = 1'b0;     waitQ();
  endtask

  task automatic stopCond();
    mDrvLow = 1'b1; waitQ();
    scl = 1'b1;     waitQ();
    mDrvLow = 1'b0; waitQ();
    waitQ();
  endtask

  task automatic clockBit(input logic drv, output logic seen, output logic steady);
    mDrvLow = ~drv; waitQ();
    scl = 1'b1;     waitQ();
    seen = line;    waitQ();
    steady = (line == seen);
    scl = 1'b0;     waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic seen, st;
    for (int i = 7; i >= 0; i--) clockBit(b[i], seen, st);
    clockBit(1'b1, seen, st);
    ack = ~seen;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b, output logic steadyAll);
    logic seen, st;
    steadyAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, seen, st);
      b[i] = seen;
      steadyAll = steadyAll & st;
    end
    clockBit(~mAck, seen, st);
  endtask

  task automatic sendAddr(input int nAddr, input logic [15:0] addr);
    logic ack;
    if (nAddr == 2) begin
      writeByte(addr[15:8], ack);
      check("R4 addr-hi ack", ack, 1);
    end
    writeByte(addr[7:0], ack);
    check("R4 addr ack", ack, 1);
  endtask

  task automatic writeRegs(input int nAddr, input logic [15:0] addr, input int n);
    logic ack;
    startCond();
    writeByte(8'hA0, ack);
    check("R4 ctrl ack", ack, 1);
    sendAddr(nAddr, addr);
    for (int k = 0; k < n; k++) begin
      writeByte(wbuf[k], ack);
      check("R4 data ack", ack, 1);
    end
    stopCond();
  endtask

  task automatic readRegs(input int nAddr, input logic [15:0] addr, input int n);
    logic ack, st;
    logic [7:0] b;
    startCond();
    writeByte(8'hA0, ack);
    check("R7 dummy-write ctrl ack", ack, 1);
    sendAddr(nAddr, addr);
    startCond();
    writeByte(8'hA1, ack);
    check("R7 read ctrl ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      readByte(k < n - 1, b, st);
      rbuf[k] = b;
      check("R10 sda steady while scl high", st, 1);
    end
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1-flow actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic ack, st;
    logic [7:0] b;
    rstN = 1'b0; scl = 1'b1; mDrvLow = 1'b0; sel = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 oe in reset", oeA, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 oe after reset", oeA, 0);
    check("R1 oe after reset (wide)", oeB, 0);
    check("R1 line idle high", line, 1);

    // Stimulus table: single-byte write then random read-back
    for (int i = 0; i < NVEC; i++) begin
      wbuf[0] = VEC[i][7:0];
      writeRegs(1, {12'h000, VEC[i][11:8]}, 1);
      readRegs(1, {12'h000, VEC[i][11:8]}, 1);
      check("R7 random read-back", rbuf[0], VEC[i][7:0]);
    end

    // R6: burst write across the end of the array, read back with master acks (R8)
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    writeRegs(1, 16'h000E, 3);
    readRegs(1, 16'h000E, 3);
    check("R6 reg14", rbuf[0], 8'h11);
    check("R8 continue reg15", rbuf[1], 8'h22);
    check("R6 wrap reg0", rbuf[2], 8'h33);

    // R9: current-address read (pointer at 1), then R8 release after NACK
    startCond();
    writeByte(8'hA1, ack);
    check("R9 ctrl ack", ack, 1);
    readByte(1'b0, b, st);
    check("R9 current-address data", b, 8'h3C);
    check("R8 released after nack", oeA, 0);
    check("R8 line high after nack", line, 1);
    stopCond();

    // R3: wrong control tag, write direction
    startCond();
    writeByte(8'h30, ack);
    check("R3 bad tag not acked", ack, 0);
    writeByte(8'h07, ack);
    check("R3 following byte not acked", ack, 0);
    writeByte(8'h99, ack);
    check("R3 data not acked", ack, 0);
    stopCond();
    readRegs(1, 16'h0007, 1);
    check("R3 register unchanged", rbuf[0], 8'hFF);
    // R3: wrong tag, read direction
    startCond();
    writeByte(8'hB1, ack);
    check("R3 bad read tag not acked", ack, 0);
    readByte(1'b0, b, st);
    check("R3 no data driven", b, 8'hFF);
    stopCond();

    // R2: after STOP, bytes without START are ignored
    scl = 1'b0; waitQ();
    writeByte(8'hA0, ack);
    check("R2 idle ignores byte", ack, 0);
    stopCond();

    // R11: START mid-byte drops the partial byte; R2: START restarts control reception
    startCond();
    writeByte(8'hA0, ack);
    check("R4 ctrl ack", ack, 1);
    writeByte(8'h04, ack);
    check("R4 addr ack", ack, 1);
    clockBit(1'b0, ack, st);
    clockBit(1'b0, ack, st);
    clockBit(1'b1, ack, st);
    clockBit(1'b0, ack, st);
    startCond();
    writeByte(8'hA1, ack);
    check("R2 ctrl after restart acked", ack, 1);
    readByte(1'b0, b, st);
    check("R11 partial byte not stored", b, 8'h81);
    stopCond();

    // R5: two-byte addressing on the wide instance
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 wide oe after reset", oeB, 0);
    sel = 1'b1;
    wbuf[0] = 8'h5A;
    writeRegs(2, 16'h0105, 1);
    wbuf[0] = 8'hC3;
    writeRegs(2, 16'h0005, 1);
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    writeRegs(2, 16'h01FF, 2);
    readRegs(2, 16'h0105, 1);
    check("R5 high byte selects 0x105", rbuf[0], 8'h5A);
    readRegs(2, 16'h0005, 1);
    check("R5 high byte selects 0x005", rbuf[0], 8'hC3);
    readRegs(2, 16'h01FF, 2);
    check("R6 wide last register", rbuf[0], 8'h77);
    check("R6 wide wrap to 0", rbuf[1], 8'h88);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule